// File: doc/BRIEF.md
# Battery Monitor Power-Control Register File

This block holds the power-management settings of a battery front-end controller and drives the outputs that follow from them. Software reaches it through a plain synchronous port: one address bus, a write strobe with write data, and a read strobe whose data appears one cycle later. There are three byte-wide registers: a control register holding a sleep request and a four-bit output-select field, a feature register holding the scan, regulator and wake-pin settings, and a write-enable register holding the lock bit for the feature register and two user flags.

Two pieces of sequential logic sit beside the registers. A temperature-scan timer counts millisecond ticks and powers the external sensor for a short window in every period, unless software turns the scan off or holds the supply on by hand. A wake detector passes the wake pin through a synchronizer and looks for an edge of the chosen polarity, which clears the sleep request. A software-forced reset returns every register, the timer and the synchronizer to zero and gives a one-cycle pulse on a dedicated output.

Top module: `bmon_pwrctl`

## Requirements
- R1: After reset all three registers read 0, and `sleep_o`, `reg_off_o` and `soft_rst_o` are 0.
- R2: A write to the feature register (address 0x7) takes effect only while bit 0 of the write-enable register (address 0x8) is 1; otherwise the register, its outputs and the forced-reset bit are left unchanged.
- R3: Writing 1 to bit 0 of the control register (address 0x4) raises `sleep_o` one cycle later; bits 7:4 of that register are a select field that is stored and read back, and a wake event leaves them unchanged.
- R4: Feature bit 5 selects the wake polarity: 1 wakes on a rising edge of `wake_pin`, 0 on a falling edge; an edge of the other direction has no effect. A wake event clears control bit 0 and drops `sleep_o`.
- R5: While feature bit 4 is 1, edges on `wake_pin` leave the sleep bit set; after a write clears feature bit 4, the next edge of the selected polarity wakes the block.
- R6: An accepted feature write with bit 3 set clears all registers to 0 and pulses `soft_rst_o` high for exactly one cycle; bit 3 itself is never stored.
- R7: With feature bits 0 and 2 both 0, `tsense_o` is high for exactly 5 of every 640 `ms_tick` pulses.
- R8: With feature bit 0 at 1 and bit 2 at 0, `tsense_o` stays low.
- R9: With feature bit 2 at 1, `tsense_o` stays high, whatever feature bit 0 holds.
- R10: Write-enable bits 1 and 2 are user flags that keep their value through sleep and wake and are cleared only by reset or the forced reset.
- R11: Feature bit 1 drives `reg_off_o`, the 3.3 V regulator disable.
- R12: Unused bits read 0 and ignore writes (control mask 0xF1, feature mask 0x37, write-enable mask 0x07); an unmapped address reads 0; read data appears one cycle after `rd_en`.
- R13: When a wake event and a control-register write fall in the same cycle, the sleep bit ends at 0 and the other control bits take the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| ms_tick | input | 1 | One pulse per millisecond |
| wake_pin | input | 1 | Asynchronous wake input |
| sleep_o | output | 1 | Sleep state, regulator off |
| reg_off_o | output | 1 | Disable the internal 3.3 V regulator |
| tsense_o | output | 1 | Temperature-sensor supply enable |
| soft_rst_o | output | 1 | One-cycle pulse on a forced reset |

## Verification
The wake detector and the control-register write port can both act on the sleep bit in the same clock cycle. The bench times a `wake_pin` transition so that the synchronized edge reaches the register exactly in the cycle a control write carrying sleep=1 and a new select value is applied. It then judges the outcome at the ports: `sleep_o` must be low and a readback must show the written select field with bit 0 cleared.

// File: rtl/pwrctl_pkg.sv
package pwrctl_pkg;

  // Control register bit positions
  localparam int CTL_NAP    = 0;
  localparam int CTL_SEL_LO = 4;

  // Feature register bit positions
  localparam int FT_SCAN_OFF = 0;
  localparam int FT_REG_OFF  = 1;
  localparam int FT_TS_MAN   = 2;
  localparam int FT_FORCE    = 3;
  localparam int FT_WK_DIS   = 4;
  localparam int FT_WK_RISE  = 5;

  // Write-enable register bit positions
  localparam int WE_FEAT = 0;

  // Writable masks
  localparam logic [7:0] CTL_MASK = 8'hF1;
  localparam logic [7:0] FT_MASK  = 8'h37;
  localparam logic [7:0] WE_MASK  = 8'h07;

  typedef struct packed {
    logic wake_rise;
    logic wake_dis;
    logic ts_manual;
    logic reg_off;
    logic scan_off;
  } feat_t;

endpackage

// File: rtl/pwrctl_wake_det.sv
module pwrctl_wake_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic pin,
  input  logic rise_sel,
  output logic edge_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   level;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (clr) sync_q <= '0;
        else     sync_q <= pin;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (clr) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      end
    end
  endgenerate

  assign level = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (clr) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  assign edge_o = rise_sel ? (level & ~prev_q) : (~level & prev_q);

  // R4: an edge report never lasts two cycles in a row
  a_r4_edge_single: assert property (@(posedge clk) disable iff (clr)
    edge_o |=> !edge_o);

endmodule

// File: rtl/pwrctl_scan_timer.sv
module pwrctl_scan_timer #(
  parameter int PERIOD   = 640,
  parameter int ON_TICKS = 5
) (
  input  logic clk,
  input  logic clr,
  input  logic tick,
  input  logic scan_off,
  input  logic manual_on,
  output logic pwr_o
);

  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] WIN  = CNT_W'(ON_TICKS);

  logic [CNT_W-1:0] cnt_q;
  logic             in_win;

  always_ff @(posedge clk) begin
    if (clr || scan_off) cnt_q <= '0;
    else if (tick) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign in_win = (cnt_q < WIN);

  always_ff @(posedge clk) begin
    if (clr) pwr_o <= 1'b0;
    else     pwr_o <= manual_on | (~scan_off & in_win);
  end

  // R7: the period counter stays inside its range
  a_r7_cnt_range: assert property (@(posedge clk) disable iff (clr)
    cnt_q <= LAST);
  // R9: manual supply holds the output on
  a_r9_manual_on: assert property (@(posedge clk) disable iff (clr)
    manual_on |=> pwr_o);
  // R8: scan off without manual keeps the output low
  a_r8_scan_off: assert property (@(posedge clk) disable iff (clr)
    (scan_off && !manual_on) |=> !pwr_o);

endmodule

// File: rtl/pwrctl_regbank.sv
module pwrctl_regbank
  import pwrctl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(4),
  parameter logic [ADDR_W-1:0] FT_ADDR  = ADDR_W'(7),
  parameter logic [ADDR_W-1:0] WE_ADDR  = ADDR_W'(8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wake_edge,
  output logic [DATA_W-1:0] rdata,
  output logic              nap,
  output feat_t             feat,
  output logic              soft_clr,
  output logic              soft_rst_q
);

  localparam logic [DATA_W-1:0] CM = DATA_W'(CTL_MASK);
  localparam logic [DATA_W-1:0] FM = DATA_W'(FT_MASK);
  localparam logic [DATA_W-1:0] WM = DATA_W'(WE_MASK);

  logic [DATA_W-1:0] ctl_q, ft_q, we_q;
  logic wr_ctl, wr_ft, wr_we, wake_ev;
  logic [DATA_W-1:0] rd_mux;

  assign wr_ctl   = wr_en && (addr == CTL_ADDR);
  assign wr_we    = wr_en && (addr == WE_ADDR);
  assign wr_ft    = wr_en && (addr == FT_ADDR) && we_q[WE_FEAT];
  assign soft_clr = wr_ft && wdata[FT_FORCE];
  assign wake_ev  = wake_edge && !ft_q[FT_WK_DIS];

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      ctl_q <= '0;
      ft_q  <= '0;
      we_q  <= '0;
    end else begin
      if (wr_ctl) ctl_q <= wdata & CM;
      if (wake_ev) ctl_q[CTL_NAP] <= 1'b0;
      if (wr_ft)  ft_q  <= wdata & FM;
      if (wr_we)  we_q  <= wdata & WM;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) soft_rst_q <= 1'b0;
    else     soft_rst_q <= soft_clr;
  end

  always_comb begin
    rd_mux = '0;
    if (addr == CTL_ADDR)     rd_mux = ctl_q;
    else if (addr == FT_ADDR) rd_mux = ft_q;
    else if (addr == WE_ADDR) rd_mux = we_q;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_clr) rdata <= '0;
    else if (rd_en)      rdata <= rd_mux;
  end

  assign nap            = ctl_q[CTL_NAP];
  assign feat.scan_off  = ft_q[FT_SCAN_OFF];
  assign feat.reg_off   = ft_q[FT_REG_OFF];
  assign feat.ts_manual = ft_q[FT_TS_MAN];
  assign feat.wake_dis  = ft_q[FT_WK_DIS];
  assign feat.wake_rise = ft_q[FT_WK_RISE];

  // R2: a locked feature write leaves the register as it was
  a_r2_feat_locked: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == FT_ADDR && !we_q[WE_FEAT]) |=> $stable(ft_q));
  // R6: forced reset empties every register
  a_r6_clear_all: assert property (@(posedge clk) disable iff (rst)
    soft_clr |=> (ctl_q == '0 && ft_q == '0 && we_q == '0));
  // R6: reset pulse is a single cycle
  a_r6_pulse_once: assert property (@(posedge clk) disable iff (rst)
    soft_rst_q |=> !soft_rst_q);
  // R5: with wake disabled, only a control write can clear sleep
  a_r5_wake_blocked: assert property (@(posedge clk) disable iff (rst)
    (nap && ft_q[FT_WK_DIS] && !wr_ctl && !soft_clr) |=> nap);
  // R10: user flags change only by a write or a clear
  a_r10_flags_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr_we && !soft_clr) |=> $stable(we_q));
  // R13: a wake event always leaves the sleep bit at 0
  a_r13_wake_wins: assert property (@(posedge clk) disable iff (rst)
    (wake_ev && !soft_clr) |=> !nap);

endmodule

// File: rtl/bmon_pwrctl.sv
module bmon_pwrctl
  import pwrctl_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int SCAN_PERIOD = 640,
  parameter int SCAN_ON     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ms_tick,
  input  logic              wake_pin,
  output logic              sleep_o,
  output logic              reg_off_o,
  output logic              tsense_o,
  output logic              soft_rst_o
);

  feat_t feat;
  logic  nap, soft_clr, wake_edge, clr_all;

  pwrctl_regbank #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .wake_edge  (wake_edge),
    .rdata      (rdata),
    .nap        (nap),
    .feat       (feat),
    .soft_clr   (soft_clr),
    .soft_rst_q (soft_rst_o)
  );

  assign clr_all = rst | soft_clr;

  pwrctl_wake_det #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_wake (
    .clk      (clk),
    .clr      (clr_all),
    .pin      (wake_pin),
    .rise_sel (feat.wake_rise),
    .edge_o   (wake_edge)
  );

  pwrctl_scan_timer #(
    .PERIOD   (SCAN_PERIOD),
    .ON_TICKS (SCAN_ON)
  ) u_scan (
    .clk       (clk),
    .clr       (clr_all),
    .tick      (ms_tick),
    .scan_off  (feat.scan_off),
    .manual_on (feat.ts_manual),
    .pwr_o     (tsense_o)
  );

  assign sleep_o   = nap;
  assign reg_off_o = feat.reg_off;

  // R3: sleep output only rises after a control write
  a_r3_sleep_by_write: assert property (@(posedge clk) disable iff (rst)
    $rose(sleep_o) |-> $past(wr_en && addr == ADDR_W'(4)));
  // R11: regulator disable only moves on an accepted feature write or clear
  a_r11_regoff_stable: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable(reg_off_o));

endmodule

// File: tb/sim_bmon_pwrctl.sv
module sim_bmon_pwrctl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ms_tick = 1'b0, wake_pin = 1'b0;
  logic       sleep_o, reg_off_o, tsense_o, soft_rst_o;

  int checks = 0;
  int fails  = 0;

  localparam logic [3:0] A_CTL = 4'h4, A_FT = 4'h7, A_WE = 4'h8;

  always #10 clk = ~clk;

  bmon_pwrctl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ms_tick(ms_tick), .wake_pin(wake_pin),
    .sleep_o(sleep_o), .reg_off_o(reg_off_o), .tsense_o(tsense_o),
    .soft_rst_o(soft_rst_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk); wake_pin = v;
    idle(5);
  endtask

  task automatic scan_count(output int n);
    @(negedge clk); ms_tick = 1'b1;
    idle(2);
    n = 0;
    for (int i = 0; i < 640; i++) begin
      @(negedge clk);
      if (tsense_o) n++;
    end
    ms_tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(A_CTL, d); check("R1 ctl", d, 0);
    rd(A_FT, d);  check("R1 feat", d, 0);
    rd(A_WE, d);  check("R1 wen", d, 0);
    check("R1 sleep_o", sleep_o, 0);
    check("R1 reg_off_o", reg_off_o, 0);
    check("R1 soft_rst_o", soft_rst_o, 0);
  endtask

  task automatic t_gate();
    logic [7:0] d;
    wr(A_FT, 8'h02);
    rd(A_FT, d); check("R2 locked feat", d, 0);
    check("R2 locked reg_off_o", reg_off_o, 0);
    wr(A_WE, 8'h01);
    wr(A_FT, 8'h02);
    rd(A_FT, d); check("R2 open feat", d, 8'h02);
    check("R11 reg_off_o on", reg_off_o, 1);
    wr(A_FT, 8'h00);
    check("R11 reg_off_o off", reg_off_o, 0);
  endtask

  task automatic t_reserved();
    logic [7:0] d;
    wr(A_WE, 8'hFF);
    rd(A_WE, d); check("R12 wen mask", d, 8'h07);
    wr(A_FT, 8'hF7);
    rd(A_FT, d); check("R12 feat mask", d, 8'h37);
    wr(A_CTL, 8'hFE);
    rd(A_CTL, d); check("R12 ctl mask", d, 8'hF0);
    rd(4'h2, d); check("R12 unmapped", d, 0);
    wr(A_FT, 8'h00);
    wr(A_CTL, 8'h00);
    wr(A_WE, 8'h01);
  endtask

  task automatic t_wake_rise();
    logic [7:0] d;
    wr(A_FT, 8'h20);
    set_pin(1'b0);
    wr(A_CTL, 8'h51);
    check("R3 sleep_o set", sleep_o, 1);
    rd(A_CTL, d); check("R3 ctl readback", d, 8'h51);
    set_pin(1'b1);
    check("R4 rising wake", sleep_o, 0);
    rd(A_CTL, d); check("R3 sel kept after wake", d, 8'h50);
  endtask

  task automatic t_wake_fall();
    logic [7:0] d;
    wr(A_FT, 8'h00);
    set_pin(1'b0);
    wr(A_CTL, 8'h61);
    set_pin(1'b1);
    check("R4 rising ignored on falling polarity", sleep_o, 1);
    set_pin(1'b0);
    check("R4 falling wake", sleep_o, 0);
    rd(A_CTL, d); check("R4 ctl after falling wake", d, 8'h60);
  endtask

  task automatic t_wake_dis();
    wr(A_FT, 8'h30);
    wr(A_CTL, 8'h01);
    set_pin(1'b1);
    check("R5 rise ignored while disabled", sleep_o, 1);
    set_pin(1'b0);
    check("R5 fall ignored while disabled", sleep_o, 1);
    wr(A_FT, 8'h20);
    check("R5 still asleep after enable", sleep_o, 1);
    set_pin(1'b1);
    check("R5 wake after enable", sleep_o, 0);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    wr(A_CTL, 8'h01);
    set_pin(1'b0);
    check("R13 asleep before collision", sleep_o, 1);
    @(negedge clk); wake_pin = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = A_CTL; wdata = 8'h31;
    @(negedge clk); wr_en = 1'b0;
    idle(1);
    check("R13 sleep_o after collision", sleep_o, 0);
    rd(A_CTL, d); check("R13 ctl after collision", d, 8'h30);
  endtask

  task automatic t_flags();
    logic [7:0] d;
    wr(A_WE, 8'h07);
    wr(A_CTL, 8'h01);
    set_pin(1'b0);
    set_pin(1'b1);
    check("R10 woke", sleep_o, 0);
    rd(A_WE, d); check("R10 flags kept", d, 8'h07);
  endtask

  task automatic t_force();
    logic [7:0] d;
    wr(A_FT, 8'h0A);
    check("R6 pulse high", soft_rst_o, 1);
    @(negedge clk);
    check("R6 pulse one cycle", soft_rst_o, 0);
    check("R6 reg_off_o cleared", reg_off_o, 0);
    rd(A_WE, d);  check("R6 wen cleared", d, 0);
    rd(A_CTL, d); check("R6 ctl cleared", d, 0);
    rd(A_FT, d);  check("R6 feat cleared", d, 0);
    wr(A_FT, 8'h08);
    check("R2 locked force ignored", soft_rst_o, 0);
  endtask

  task automatic t_scan();
    int n;
    scan_count(n); check("R7 scan window", n, 5);
    wr(A_WE, 8'h01);
    wr(A_FT, 8'h01);
    scan_count(n); check("R8 scan off", n, 0);
    wr(A_FT, 8'h04);
    scan_count(n); check("R9 manual on", n, 640);
    wr(A_FT, 8'h05);
    scan_count(n); check("R9 manual with scan off", n, 640);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_gate();
    t_reserved();
    t_wake_rise();
    t_wake_fall();
    t_wake_dis();
    t_collide();
    t_flags();
    t_force();
    t_scan();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule